// File: doc/BRIEF.md
# E1 Timeslot-0 CRC-4 Multiframe Transmit Generator

This block sits in the serial transmit path of a 2.048 Mbit/s E1 line. It receives the outgoing frame stream one bit at a time, qualified by a bit-clock enable. A strobe marks the first bit of each 256-bit frame. The block keeps its own count of the 16-frame CRC-4 multiframe and rewrites the first eight bit positions of every frame (timeslot 0). All other bit positions pass through unchanged. Line coding and payload assembly happen elsewhere.

Even frames carry the fixed alignment word in bits 2 to 8. Odd frames carry a constant 1, the remote alarm and five spare bits. Bit 1 of each frame depends on the frame number. Even frames send one bit of a four-bit CRC. Frames 1 to 11 send the multiframe alignment pattern. Frames 13 and 15 send the two error-report (E) bits.

The CRC is a 4-bit remainder taken over each half-multiframe of 2048 bits. It is transmitted in the half that follows. The receiver raises a one-cycle pulse for each errored half-multiframe it sees. The block holds that pulse until the next E-bit slot and reports it there.

After the first frame strobe, the frame counters keep running on their own (flywheel). A later strobe re-aligns them.

Top module: `e1_crc4_txgen`

## Requirements
- R1: The first `frame_start` after reset begins frame 0, and frame numbers then run 0 to 15 and wrap. Each further strobe starts the next frame. If no strobe comes, a new frame starts by itself 256 enabled bits after the previous one began.
- R2: From reset until the first `frame_start`, `data_out` is 1. Otherwise `data_out` takes the output value of a bit on the clock edge where `bit_en` is 1, and holds while `bit_en` is 0.
- R3: Bit positions 9 to 256 of each frame copy `data_in` to `data_out`. The value of `data_in` in positions 1 to 8 has no effect on the output.
- R4: In even frames, bits 2 to 8 are sent as 0,0,1,1,0,1,1, in that order.
- R5: In odd frames, bit 2 is 1 and bit 3 equals `remote_alarm` (1 means alarm). Bits 4 to 8 send `sa_bits[4]` down to `sa_bits[0]`, in that order.
- R6: Bit 1 of frames 1, 3, 5, 7, 9 and 11 is 0, 0, 1, 0, 1, 1 respectively.
- R7: Frames 0 to 7 form the first half-multiframe and frames 8 to 15 the second. In the even frames of a half, bit 1 sends C1, C2, C3 and C4 in frame order. C1 is the x^3 coefficient of the remainder, modulo x^4+x+1, of x^4 times the previous half's 2048 transmitted bits (first bit = highest order). The C positions count as 0 in that remainder. The first half after reset sends 0000.
- R8: Bit 1 of frames 13 and 15 is an E bit. When `ebit_en` is 0, both E bits are sent as 1.
- R9: When `ebit_en` is 1 but `frame_aligned` and `mf_aligned` are not both 1, the E bits are sent as 0.
- R10: A one-cycle `smf_err` pulse is held until the next E-bit slot, in any mode, and that slot consumes it. With `ebit_en` and both alignment inputs at 1, an E bit is 0 if a pulse is held, otherwise 1. A pulse in the same cycle as a consuming E slot is held for the following slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per transmitted bit |
| frame_start | input | 1 | With `bit_en`, marks bit 1 of a frame |
| data_in | input | 1 | Incoming serial frame bit |
| frame_aligned | input | 1 | Local basic frame alignment reached |
| mf_aligned | input | 1 | Local CRC-4 multiframe alignment reached |
| ebit_en | input | 1 | 1 = report errors in E bits, 0 = send E bits as 1 |
| remote_alarm | input | 1 | Remote alarm value for bit 3 of odd frames |
| sa_bits | input | 5 | Spare bit values; bit 4 is sent first |
| smf_err | input | 1 | Pulse: receiver found one errored half-multiframe |
| data_out | output | 1 | Outgoing serial frame bit |

## Verification
The hardest case to reach is a CRC value that is correct over a whole 2048-bit half. The value sent in one half comes from every bit of the half before it, including the rewritten timeslot-0 bits. The bench runs five complete multiframes with payload patterns that vary bit by bit, and it drives the timeslot-0 inputs to the inverse of their expected output. It records each expected output bit and computes the remainder by long division over the stored half. Error pulses are placed well before an E slot, between the two slots, and in the very cycle of the frame-15 slot. This covers both the carry-over and the consumption rule. One multiframe is sent with no frame strobes, so the flywheel counting is tested.

// File: rtl/e1_crc4_pkg.sv
package e1_crc4_pkg;

    localparam int unsigned TS0_BITS = 8;
    localparam int unsigned CRC_W    = 4;
    localparam int unsigned SA_W     = 5;

    // Bits 2..8 of an alignment frame, first sent bit in the MSB.
    localparam logic [6:0] ALIGN_TAIL = 7'b0011011;
    // Bit 1 of odd frames 1..11, first frame in the MSB.
    localparam logic [5:0] MF_PATTERN = 6'b001011;

    typedef enum logic [2:0] {
        K_PAYLOAD,
        K_CRC,
        K_MFAS,
        K_EBIT,
        K_ALIGN,
        K_FIXED_ONE,
        K_ALARM,
        K_SPARE
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e  kind;
        logic [2:0]  idx;
    } slot_t;

    // Decide what a bit position carries, from frame number and bit position.
    function automatic slot_t classify(input int unsigned frame,
                                       input int unsigned pos,
                                       input int unsigned mf_frames);
        slot_t       s;
        int unsigned half;
        half   = mf_frames / 2;
        s.kind = K_PAYLOAD;
        s.idx  = '0;
        if (pos < TS0_BITS) begin
            if ((frame % 2) == 0) begin
                if (pos == 0) begin
                    s.kind = K_CRC;
                    s.idx  = 3'((frame % half) / 2);
                end else begin
                    s.kind = K_ALIGN;
                    s.idx  = 3'(pos - 1);
                end
            end else if (pos == 0) begin
                if (frame >= mf_frames - 3) begin
                    s.kind = K_EBIT;
                    s.idx  = (frame == mf_frames - 1) ? 3'd1 : 3'd0;
                end else begin
                    s.kind = K_MFAS;
                    s.idx  = 3'((frame - 1) / 2);
                end
            end else if (pos == 1) begin
                s.kind = K_FIXED_ONE;
            end else if (pos == 2) begin
                s.kind = K_ALARM;
            end else begin
                s.kind = K_SPARE;
                s.idx  = 3'(pos - 3);
            end
        end
        return s;
    endfunction

    // One serial step of division by x^4 + poly, with the x^4 multiply folded in.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                  input logic             din,
                                                  input logic [CRC_W-1:0] poly);
        logic fb;
        fb = din ^ cur[CRC_W-1];
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/e1_ts0_timing.sv
module e1_ts0_timing #(
    parameter  int unsigned FRAME_BITS = 256,
    parameter  int unsigned MF_FRAMES  = 16,
    localparam int unsigned POS_W      = $clog2(FRAME_BITS),
    localparam int unsigned FRM_W      = $clog2(MF_FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             frame_start,
    output logic             active,
    output logic             running,
    output logic [FRM_W-1:0] cur_frame,
    output logic [POS_W-1:0] cur_pos,
    output logic             half_first
);

    logic             started_q;
    logic [FRM_W-1:0] frm_q;
    logic [POS_W-1:0] pos_q;
    logic             wrap;
    logic [FRM_W-1:0] frm_inc;

    always_comb begin
        wrap    = (pos_q == POS_W'(FRAME_BITS - 1));
        frm_inc = (frm_q == FRM_W'(MF_FRAMES - 1)) ? '0 : frm_q + 1'b1;
        active  = started_q | frame_start;
        if (frame_start) begin
            cur_pos   = '0;
            cur_frame = started_q ? frm_inc : '0;
        end else if (wrap) begin
            cur_pos   = '0;
            cur_frame = frm_inc;
        end else begin
            cur_pos   = pos_q + 1'b1;
            cur_frame = frm_q;
        end
        // Frames 0 and MF_FRAMES/2 open a half-multiframe.
        half_first = (cur_pos == '0) && (cur_frame[FRM_W-2:0] == '0);
    end

    assign running = started_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b0;
            frm_q     <= '0;
            pos_q     <= POS_W'(FRAME_BITS - 1);
        end else if (bit_en && active) begin
            started_q <= 1'b1;
            frm_q     <= cur_frame;
            pos_q     <= cur_pos;
        end
    end

    // R1: the frame number only moves together with a return to bit position 0.
    p_frame_at_pos0_r1: assert property (@(posedge clk) disable iff (rst)
        !$stable(frm_q) |-> (pos_q == '0));

endmodule

// File: rtl/e1_crc4_engine.sv
module e1_crc4_engine
    import e1_crc4_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_W'(3)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             half_first,
    input  logic             crc_bit,
    output logic [CRC_W-1:0] c_word
);

    logic [CRC_W-1:0] rem_q;
    logic [CRC_W-1:0] held_q;
    logic [CRC_W-1:0] seed;

    always_comb begin
        seed   = half_first ? '0 : rem_q;
        // At the first bit of a half the finished remainder is used directly.
        c_word = half_first ? rem_q : held_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            held_q <= '0;
        end else if (step) begin
            rem_q <= crc_step(seed, crc_bit, POLY);
            if (half_first) begin
                held_q <= rem_q;
            end
        end
    end

    // R7: the word being sent changes only at a half-multiframe boundary.
    p_cword_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(step && half_first) |=> $stable(held_q));

endmodule

// File: rtl/e1_ebit_ctrl.sv
module e1_ebit_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic err_pulse,
    input  logic consume,
    input  logic use_ebits,
    input  logic fas_ok,
    input  logic mfa_ok,
    output logic e_val
);

    logic pend_q;

    always_comb begin
        if (!use_ebits) begin
            e_val = 1'b1;
        end else if (!(fas_ok && mfa_ok)) begin
            e_val = 1'b0;
        end else begin
            e_val = !pend_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~consume) | err_pulse;
        end
    end

    // R10: a report request is never lost before an E slot takes it.
    p_err_latched_r10: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> pend_q);

    // R10: an E slot with no new request leaves nothing pending.
    p_err_consumed_r10: assert property (@(posedge clk) disable iff (rst)
        (consume && !err_pulse) |=> !pend_q);

endmodule

// File: rtl/e1_ts0_mux.sv
module e1_ts0_mux
    import e1_crc4_pkg::*;
(
    input  slot_t            slot,
    input  logic [CRC_W-1:0] c_word,
    input  logic             e_val,
    input  logic             remote_alarm,
    input  logic [SA_W-1:0]  sa_bits,
    input  logic             data_in,
    output logic             tx_bit,
    output logic             crc_bit
);

    logic [CRC_W-1:0] c_shift;
    logic [6:0]       a_shift;
    logic [5:0]       m_shift;
    logic [SA_W-1:0]  s_shift;

    always_comb begin
        c_shift = c_word << slot.idx;
        a_shift = ALIGN_TAIL << slot.idx;
        m_shift = MF_PATTERN << slot.idx;
        s_shift = sa_bits << slot.idx;
        unique case (slot.kind)
            K_CRC:       tx_bit = c_shift[CRC_W-1];
            K_ALIGN:     tx_bit = a_shift[6];
            K_MFAS:      tx_bit = m_shift[5];
            K_EBIT:      tx_bit = e_val;
            K_FIXED_ONE: tx_bit = 1'b1;
            K_ALARM:     tx_bit = remote_alarm;
            K_SPARE:     tx_bit = s_shift[SA_W-1];
            default:     tx_bit = data_in;
        endcase
        // C positions enter the running remainder as zeros.
        crc_bit = (slot.kind == K_CRC) ? 1'b0 : tx_bit;
    end

endmodule

// File: rtl/e1_crc4_txgen.sv
module e1_crc4_txgen
    import e1_crc4_pkg::*;
#(
    parameter int unsigned      FRAME_BITS = 256,
    parameter int unsigned      MF_FRAMES  = 16,
    parameter logic [CRC_W-1:0] CRC_POLY   = 4'b0011
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_en,
    input  logic            frame_start,
    input  logic            data_in,
    input  logic            frame_aligned,
    input  logic            mf_aligned,
    input  logic            ebit_en,
    input  logic            remote_alarm,
    input  logic [SA_W-1:0] sa_bits,
    input  logic            smf_err,
    output logic            data_out
);

    localparam int unsigned POS_W = $clog2(FRAME_BITS);
    localparam int unsigned FRM_W = $clog2(MF_FRAMES);

    logic             active;
    logic             running;
    logic [FRM_W-1:0] cur_frame;
    logic [POS_W-1:0] cur_pos;
    logic             half_first;
    logic             step;
    slot_t            slot;
    logic [CRC_W-1:0] c_word;
    logic             e_val;
    logic             tx_bit;
    logic             crc_bit;
    logic             e_consume;

    e1_ts0_timing #(
        .FRAME_BITS (FRAME_BITS),
        .MF_FRAMES  (MF_FRAMES)
    ) u_timing (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .frame_start (frame_start),
        .active      (active),
        .running     (running),
        .cur_frame   (cur_frame),
        .cur_pos     (cur_pos),
        .half_first  (half_first)
    );

    always_comb begin
        step      = bit_en && active;
        slot      = classify(32'(cur_frame), 32'(cur_pos), MF_FRAMES);
        e_consume = step && (slot.kind == K_EBIT);
    end

    e1_crc4_engine #(
        .POLY (CRC_POLY)
    ) u_crc (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .half_first (half_first),
        .crc_bit    (crc_bit),
        .c_word     (c_word)
    );

    e1_ebit_ctrl u_ebit (
        .clk       (clk),
        .rst       (rst),
        .err_pulse (smf_err),
        .consume   (e_consume),
        .use_ebits (ebit_en),
        .fas_ok    (frame_aligned),
        .mfa_ok    (mf_aligned),
        .e_val     (e_val)
    );

    e1_ts0_mux u_mux (
        .slot         (slot),
        .c_word       (c_word),
        .e_val        (e_val),
        .remote_alarm (remote_alarm),
        .sa_bits      (sa_bits),
        .data_in      (data_in),
        .tx_bit       (tx_bit),
        .crc_bit      (crc_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= 1'b1;
        end else if (step) begin
            data_out <= tx_bit;
        end
    end

    // R2: idle marking until the frame counters have been started.
    p_idle_until_start_r2: assert property (@(posedge clk) disable iff (rst)
        !running |-> data_out);

    // R2: the output only moves on an enabled bit.
    p_hold_without_enable_r2: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(data_out));

    // R3: payload positions are copied from the input.
    p_payload_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (step && slot.kind == K_PAYLOAD) |=> (data_out == $past(data_in)));

    // R8: E bits are 1 when reporting is switched off.
    p_ebit_disabled_r8: assert property (@(posedge clk) disable iff (rst)
        (e_consume && !ebit_en) |=> data_out);

    // R9: E bits are 0 while either alignment is missing.
    p_ebit_unaligned_r9: assert property (@(posedge clk) disable iff (rst)
        (e_consume && ebit_en && !(frame_aligned && mf_aligned)) |=> !data_out);

endmodule

// File: tb/e1_crc4_txgen_bench.sv
module e1_crc4_txgen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int FBITS      = 256;
    localparam int NFRAMES    = 16;
    localparam int NMF        = 5;
    localparam int HALF_BITS  = FBITS * NFRAMES / 2;
    localparam int WD_CYCLES  = 150000;
    localparam logic [6:0] ALIGN_EXP = 7'b0011011;
    localparam logic [5:0] MFAS_EXP  = 6'b001011;

    logic       clk = 1'b0;
    logic       rst;
    logic       bit_en;
    logic       frame_start;
    logic       data_in;
    logic       frame_aligned;
    logic       mf_aligned;
    logic       ebit_en;
    logic       remote_alarm;
    logic [4:0] sa_bits;
    logic       smf_err;
    logic       data_out;

    int vectors     = 0;
    int miscompares = 0;
    bit done        = 1'b0;

    bit         half_buf [HALF_BITS];
    logic [3:0] prev_rem;
    bit         pend;
    int         bit_count;

    e1_crc4_txgen u_e1_crc4_txgen (
        .clk           (clk),
        .rst           (rst),
        .bit_en        (bit_en),
        .frame_start   (frame_start),
        .data_in       (data_in),
        .frame_aligned (frame_aligned),
        .mf_aligned    (mf_aligned),
        .ebit_en       (ebit_en),
        .remote_alarm  (remote_alarm),
        .sa_bits       (sa_bits),
        .smf_err       (smf_err),
        .data_out      (data_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: data_out=%b expected %b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic tx_bit(input logic d, input logic fs, input logic pulse,
                          input logic exp, input string tag);
        data_in     = d;
        frame_start = fs;
        smf_err     = pulse;
        bit_en      = 1'b1;
        @(negedge clk);
        bit_en      = 1'b0;
        frame_start = 1'b0;
        smf_err     = 1'b0;
        check(data_out, exp, tag);
    endtask

    // Long division of (half bits)*x^4 by x^4+x+1.
    function automatic logic [3:0] half_remainder();
        logic [4:0] r;
        r = '0;
        for (int i = 0; i < HALF_BITS + 4; i++) begin
            r = {r[3:0], (i < HALF_BITS) ? half_buf[i] : 1'b0};
            if (r[4]) r = r ^ 5'b10011;
        end
        return r[3:0];
    endfunction

    function automatic logic pulse_at(input int mf, input int fr, input int pos);
        case (mf)
            0: return (fr == 5  && pos == 100);
            1: return (fr == 10 && pos == 40);
            2: return (fr == 12 && pos == 7);
            3: return (fr == 2 && pos == 9) || (fr == 14 && pos == 3) || (fr == 15 && pos == 0);
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic d, ex, fs, pl, cons, fa, ma, en, al;
        logic [4:0] sa;
        string tag;

        rst = 1'b1; bit_en = 1'b0; frame_start = 1'b0; data_in = 1'b0;
        frame_aligned = 1'b0; mf_aligned = 1'b0; ebit_en = 1'b0;
        remote_alarm = 1'b0; sa_bits = '0; smf_err = 1'b0;
        prev_rem = '0; pend = 1'b0; bit_count = 0;
        repeat (4) @(negedge clk);
        check(data_out, 1'b1, "R2 reset");
        rst = 1'b0;
        @(negedge clk);
        check(data_out, 1'b1, "R2 after reset");

        // R2: enabled bits before any frame strobe leave the line idle.
        for (int i = 0; i < 3; i++) tx_bit(1'b0, 1'b0, 1'b0, 1'b1, "R2 pre-start");

        for (int mf = 0; mf < NMF; mf++) begin
            fa = (mf != 0);
            ma = 1'b1;
            en = (mf != 2);
            al = (mf % 2 == 1);
            sa = 5'(mf * 7 + 9);
            frame_aligned = fa; mf_aligned = ma; ebit_en = en;
            remote_alarm = al; sa_bits = sa;
            for (int fr = 0; fr < NFRAMES; fr++) begin
                for (int pos = 0; pos < FBITS; pos++) begin
                    fs   = (pos == 0) && !(mf == 2 && fr != 0);
                    d    = ((pos * 5 + fr * 3 + mf + pos / 7) % 2) == 1;
                    cons = 1'b0;
                    if (pos >= 8) begin
                        ex = d; tag = "R3 payload";
                    end else if (fr % 2 == 0) begin
                        if (pos == 0) begin
                            ex = prev_rem[3 - ((fr % 8) / 2)]; tag = "R7 crc bit";
                        end else begin
                            ex = ALIGN_EXP[6 - (pos - 1)]; tag = "R4 align word";
                        end
                    end else if (pos == 0) begin
                        if (fr >= 13) begin
                            cons = 1'b1;
                            if (!en) begin
                                ex = 1'b1; tag = "R8 e disabled";
                            end else if (!(fa && ma)) begin
                                ex = 1'b0; tag = "R9 e unaligned";
                            end else begin
                                ex = !pend; tag = "R10 e report";
                            end
                        end else begin
                            ex = MFAS_EXP[5 - ((fr - 1) / 2)]; tag = "R6 mf pattern";
                        end
                    end else if (pos == 1) begin
                        ex = 1'b1; tag = "R5 fixed one";
                    end else if (pos == 2) begin
                        ex = al; tag = "R5 alarm";
                    end else begin
                        ex = sa[4 - (pos - 3)]; tag = "R5 spare";
                    end
                    if (pos < 8) begin
                        d = ~ex;    // R3: input in timeslot 0 must not show
                        if (mf == 2 && fr != 0) tag = {"R1 flywheel ", tag};
                    end
                    pl = pulse_at(mf, fr, pos);
                    half_buf[(fr % 8) * FBITS + pos] = (pos == 0 && fr % 2 == 0) ? 1'b0 : ex;
                    tx_bit(d, fs, pl, ex, tag);
                    if (cons) pend = 1'b0;
                    if (pl)   pend = 1'b1;
                    bit_count++;
                    if (bit_count % 5 == 4) begin
                        repeat (2) @(negedge clk);
                        check(data_out, ex, "R2 hold");
                    end
                    if (pos == FBITS - 1 && fr % 8 == 7) prev_rem = half_remainder();
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule